// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the register bank of a multi-channel DMA controller. It sits on a simple word-addressed register port and keeps the state that software uses to steer the channel engines and watch their progress. That state covers a freeze bit and a reset bit for each channel, two bus burst enables, a completion flag and interrupt enable for each channel, and an error flag with an error-type bit for each channel. A read-only version word completes the set. Each write carries an operation code. A plain write replaces the register. A set write ORs the data in. A clear write removes the bits written as 1. In every case the other bits keep their value.

The channel engines report completions and errors as one-cycle event vectors, and the bank latches them into the status flags. The bank drives a freeze level and a one-cycle reset pulse to each channel. It also raises a single interrupt line when any enabled completion or any qualified error is pending. An error counts as qualified if it is a bus error. A termination error counts as qualified only if the same channel has no completion pending, so a termination that arrives together with its completion does not show up as an error.

Top module: `dmareg_bank`

## Requirements
- R1: After reset every register reads 0 except the version word. `irq`, `chan_freeze` and `chan_reset` are all 0.
- R2: The channel control register is at word 3. A write to it stores the freeze bits in 15:0, channel n at bit n. `chan_freeze` follows those bits from the cycle after the write.
- R3: `reg_op` selects the write operation: 0 or 3 is a plain write, 1 is set (OR), 2 is clear (AND with the inverted data). Set and clear leave unwritten bits unchanged.
- R4: Channel n's reset bit is bit 16+n of word 3. Writing it as 1 drives `chan_reset[n]` high for exactly one cycle. After that the bit reads 0 again, with no further write needed.
- R5: The first control register is at word 0. It stores only a burst enable at bit 28 and an 8-beat burst enable at bit 29. All its other bits read 0.
- R6: Word 1 holds the completion flags in 15:0 and the interrupt enables in 31:16. `evt_done[n]` sets flag n, and the flag stays set until software clears it.
- R7: Word 2 holds the error flags in 15:0 and the error types in 31:16. `evt_err[n]` sets flag n and loads type bit 16+n from `evt_err_bus[n]`: 1 means a bus error, 0 means a termination error.
- R8: `irq` is high exactly while some channel has both its completion flag and its enable set, or has a qualified error. A qualified error is a bus error, or a termination error on a channel whose completion flag is clear.
- R9: When a completion or error event and a software write that would clear the same flag fall in the same cycle, the flag ends up set.
- R10: Word 4 is read-only. It reads the major version 3 in bits 31:24 and 0 in all other bits, and writes to it change nothing.
- R11: Reads of any word above 4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_op | input | 2 | Write operation: 0/3 write, 1 set, 2 clear |
| reg_addr | input | ADDR_W | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| evt_done | input | NCH | Completion event per channel |
| evt_err | input | NCH | Error event per channel |
| evt_err_bus | input | NCH | Error type with evt_err: 1 bus, 0 termination |
| irq | output | 1 | Combined interrupt |
| chan_freeze | output | NCH | Freeze level per channel |
| chan_reset | output | NCH | One-cycle reset pulse per channel |

## Verification
Two things can happen to the same status flag in one cycle: a software clear or overwrite, and a hardware event. The random phase drives writes to the status words with random operation codes in the same cycles as sparse random events, so these collisions happen often. A directed case clears a completion flag in the very cycle its event fires and expects the flag to read back as 1. A second directed case raises a termination error together with its completion and expects `irq` to stay low while the enables are off.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

   typedef enum logic [1:0] {
      OP_WRITE  = 2'd0,
      OP_SET    = 2'd1,
      OP_CLEAR  = 2'd2,
      OP_WRITE3 = 2'd3
   } reg_op_e;

   localparam int IDX_CTRL   = 0;
   localparam int IDX_STAT1  = 1;
   localparam int IDX_STAT2  = 2;
   localparam int IDX_CHCTRL = 3;
   localparam int IDX_VER    = 4;
   localparam int HALF       = 16;
   localparam int BIT_BURST  = 28;

endpackage

// File: rtl/dmareg_alias_field.sv
module dmareg_alias_field
   import dmareg_pkg::*;
#(
   parameter int W          = 16,
   parameter bit SELF_CLEAR = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [1:0]   op,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   logic [W-1:0] sw_v;
   logic [W-1:0] idle_v;

   generate
      if (SELF_CLEAR) begin : g_pulse
         assign idle_v = '0;
      end else begin : g_hold
         assign idle_v = q;
      end
   endgenerate

   always_comb begin
      sw_v = idle_v;
      if (wr_en) begin
         unique case (reg_op_e'(op))
            OP_SET:   sw_v = q | wdata;
            OP_CLEAR: sw_v = q & ~wdata;
            default:  sw_v = wdata;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= sw_v | hw_set;
   end
endmodule

// File: rtl/dmareg_err_field.sv
module dmareg_err_field
   import dmareg_pkg::*;
#(
   parameter int NCH = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [1:0]     op,
   input  logic [NCH-1:0] wd_flag,
   input  logic [NCH-1:0] wd_type,
   input  logic [NCH-1:0] evt_err,
   input  logic [NCH-1:0] evt_bus,
   output logic [NCH-1:0] flag_q,
   output logic [NCH-1:0] type_q
);
   logic [NCH-1:0] f_sw, t_sw;

   always_comb begin
      f_sw = flag_q;
      t_sw = type_q;
      if (wr_en) begin
         unique case (reg_op_e'(op))
            OP_SET:   begin f_sw = flag_q | wd_flag;  t_sw = type_q | wd_type;  end
            OP_CLEAR: begin f_sw = flag_q & ~wd_flag; t_sw = type_q & ~wd_type; end
            default:  begin f_sw = wd_flag;           t_sw = wd_type;           end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         type_q <= '0;
      end else begin
         flag_q <= f_sw | evt_err;
         type_q <= (evt_err & evt_bus) | (~evt_err & t_sw);
      end
   end
endmodule

// File: rtl/dmareg_irq.sv
module dmareg_irq #(
   parameter int NCH     = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] done_q,
   input  logic [NCH-1:0] en_q,
   input  logic [NCH-1:0] err_q,
   input  logic [NCH-1:0] type_q,
   output logic           irq
);
   logic [NCH-1:0] qual_err;
   logic           irq_n;

   assign qual_err = err_q & (type_q | ~done_q);
   assign irq_n    = |(done_q & en_q) | |qual_err;

   generate
      if (IRQ_REG) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= irq_n;
         end
      end else begin : g_comb
         assign irq = irq_n;
      end
   endgenerate
endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
   import dmareg_pkg::*;
#(
   parameter int          NCH       = 16,
   parameter int          ADDR_W    = 3,
   parameter logic [7:0]  VER_MAJOR = 8'd3,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_op,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NCH-1:0]    evt_done,
   input  logic [NCH-1:0]    evt_err,
   input  logic [NCH-1:0]    evt_err_bus,
   output logic              irq,
   output logic [NCH-1:0]    chan_freeze,
   output logic [NCH-1:0]    chan_reset
);
   localparam int HI = HALF;

   generate
      if (NCH < 1 || NCH > HALF) begin : g_bad_nch
         $error("NCH must lie in 1..16");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must be at least 3");
      end
   endgenerate

   logic wr_ctrl, wr_s1, wr_s2, wr_ch;
   assign wr_ctrl = reg_wr && reg_addr == ADDR_W'(IDX_CTRL);
   assign wr_s1   = reg_wr && reg_addr == ADDR_W'(IDX_STAT1);
   assign wr_s2   = reg_wr && reg_addr == ADDR_W'(IDX_STAT2);
   assign wr_ch   = reg_wr && reg_addr == ADDR_W'(IDX_CHCTRL);

   logic [1:0]     burst_q;
   logic [NCH-1:0] done_q, en_q, err_q, type_q;

   dmareg_alias_field #(.W(2), .SELF_CLEAR(1'b0)) u_ctrl (
      .clk, .rst_n, .wr_en(wr_ctrl), .op(reg_op),
      .wdata(reg_wdata[BIT_BURST+:2]), .hw_set(2'b00), .q(burst_q));

   dmareg_alias_field #(.W(NCH), .SELF_CLEAR(1'b0)) u_freeze (
      .clk, .rst_n, .wr_en(wr_ch), .op(reg_op),
      .wdata(reg_wdata[NCH-1:0]), .hw_set({NCH{1'b0}}), .q(chan_freeze));

   dmareg_alias_field #(.W(NCH), .SELF_CLEAR(1'b1)) u_reset (
      .clk, .rst_n, .wr_en(wr_ch), .op(reg_op),
      .wdata(reg_wdata[HI+:NCH]), .hw_set({NCH{1'b0}}), .q(chan_reset));

   dmareg_alias_field #(.W(NCH), .SELF_CLEAR(1'b0)) u_done (
      .clk, .rst_n, .wr_en(wr_s1), .op(reg_op),
      .wdata(reg_wdata[NCH-1:0]), .hw_set(evt_done), .q(done_q));

   dmareg_alias_field #(.W(NCH), .SELF_CLEAR(1'b0)) u_en (
      .clk, .rst_n, .wr_en(wr_s1), .op(reg_op),
      .wdata(reg_wdata[HI+:NCH]), .hw_set({NCH{1'b0}}), .q(en_q));

   dmareg_err_field #(.NCH(NCH)) u_err (
      .clk, .rst_n, .wr_en(wr_s2), .op(reg_op),
      .wd_flag(reg_wdata[NCH-1:0]), .wd_type(reg_wdata[HI+:NCH]),
      .evt_err, .evt_bus(evt_err_bus), .flag_q(err_q), .type_q(type_q));

   dmareg_irq #(.NCH(NCH), .IRQ_REG(IRQ_REG)) u_irq (
      .clk, .rst_n, .done_q, .en_q, .err_q, .type_q, .irq);

   function automatic logic [31:0] pack(input logic [NCH-1:0] lo, input logic [NCH-1:0] hi);
      logic [31:0] r;
      r = '0;
      r[NCH-1:0] = lo;
      r[HI+:NCH] = hi;
      return r;
   endfunction

   always_comb begin
      reg_rdata = '0;
      unique case (int'(reg_addr))
         IDX_CTRL:   reg_rdata[BIT_BURST+:2] = burst_q;
         IDX_STAT1:  reg_rdata = pack(done_q, en_q);
         IDX_STAT2:  reg_rdata = pack(err_q, type_q);
         IDX_CHCTRL: reg_rdata = pack(chan_freeze, chan_reset);
         IDX_VER:    reg_rdata[31:24] = VER_MAJOR;
         default:    reg_rdata = '0;
      endcase
   end

   // R4
   reset_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> chan_reset == '0);

   // R2
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(chan_freeze));

   // R9
   done_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done != '0 |=> (done_q & $past(evt_done)) == $past(evt_done));

   // R7
   err_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_err != '0 |=> (err_q & $past(evt_err)) == $past(evt_err));

   // R7
   err_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_err != '0 |=> (type_q & $past(evt_err)) == ($past(evt_err_bus) & $past(evt_err)));

   generate
      if (!IRQ_REG) begin : g_irq_chk
         // R8
         irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!reg_wr && evt_done == '0 && evt_err == '0) |=> $stable(irq));
      end
   endgenerate
endmodule

// File: tb/sim_dmareg_bank.sv
module sim_dmareg_bank;
   localparam int NCH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_op = 2'd0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] evt_done = '0, evt_err = '0, evt_err_bus = '0;
   logic        irq;
   logic [15:0] chan_freeze, chan_reset;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dmareg_bank #(.NCH(NCH), .ADDR_W(3)) u0 (
      .clk, .rst_n, .reg_wr, .reg_op, .reg_addr, .reg_wdata, .reg_rdata,
      .evt_done, .evt_err, .evt_err_bus, .irq, .chan_freeze, .chan_reset);

   // expected state
   logic [1:0]  m_ctl;
   logic [15:0] m_frz, m_rst, m_done, m_en, m_err, m_typ;

   function automatic logic [31:0] alias_op(input logic [1:0] op, input logic [31:0] old,
                                            input logic [31:0] wd);
      if (op == 2'd1)      return old | wd;
      else if (op == 2'd2) return old & ~wd;
      else                 return wd;
   endfunction

   function automatic logic [31:0] exp_read(input logic [2:0] a);
      case (a)
         3'd0: return {2'b00, m_ctl, 28'h0};
         3'd1: return {m_en, m_done};
         3'd2: return {m_typ, m_err};
         3'd3: return {m_rst, m_frz};
         3'd4: return 32'h0300_0000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic exp_irq();
      return (|(m_done & m_en)) | (|(m_err & (m_typ | ~m_done)));
   endfunction

   function automatic string rtag(input logic [2:0] a);
      case (a)
         3'd0: return "R5";
         3'd1: return "R6";
         3'd2: return "R7";
         3'd3: return "R2";
         3'd4: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic [2:0] a, input logic [1:0] op,
                       input logic [31:0] wd, input logic [15:0] ed, input logic [15:0] ee,
                       input logic [15:0] eb);
      logic [31:0] v;
      logic [1:0]  n_ctl;
      logic [15:0] n_frz, n_rst, n_done, n_en, n_err, n_typ;
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_op = op; reg_wdata = wd;
      evt_done = ed; evt_err = ee; evt_err_bus = eb;
      n_ctl = m_ctl; n_frz = m_frz; n_rst = '0; n_done = m_done; n_en = m_en;
      n_err = m_err; n_typ = m_typ;
      if (wr && a == 3'd0) begin
         v = alias_op(op, {2'b00, m_ctl, 28'h0}, wd);
         n_ctl = v[29:28];
      end
      if (wr && a == 3'd3) begin
         v = alias_op(op, {m_rst, m_frz}, wd);
         n_frz = v[15:0]; n_rst = v[31:16];
      end
      if (wr && a == 3'd1) begin
         v = alias_op(op, {m_en, m_done}, wd);
         n_done = v[15:0]; n_en = v[31:16];
      end
      if (wr && a == 3'd2) begin
         v = alias_op(op, {m_typ, m_err}, wd);
         n_err = v[15:0]; n_typ = v[31:16];
      end
      n_done = n_done | ed;
      n_err  = n_err | ee;
      n_typ  = (ee & eb) | (~ee & n_typ);
      @(posedge clk);
      #1;
      m_ctl = n_ctl; m_frz = n_frz; m_rst = n_rst; m_done = n_done;
      m_en = n_en; m_err = n_err; m_typ = n_typ;
      chk("R2 freeze", {16'h0, chan_freeze}, {16'h0, m_frz});
      chk("R4 reset pulse", {16'h0, chan_reset}, {16'h0, m_rst});
      chk("R8 irq", {31'h0, irq}, {31'h0, exp_irq()});
      chk({rtag(a), " read"}, reg_rdata, exp_read(a));
   endtask

   task automatic idle(input logic [2:0] a);
      step(1'b0, a, 2'd0, 32'h0, 16'h0, 16'h0, 16'h0);
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd1234);
      m_ctl = '0; m_frz = '0; m_rst = '0; m_done = '0; m_en = '0; m_err = '0; m_typ = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state of every word
      for (int a = 0; a < 6; a++) begin
         idle(3'(a));
         chk("R1 reset read", reg_rdata, (a == 4) ? 32'h0300_0000 : 32'h0);
      end
      chk("R1 irq", {31'h0, irq}, 32'h0);

      // R5 burst enables set through the set alias; other bits dropped
      step(1'b1, 3'd0, 2'd1, 32'hFFFF_FFFF, 16'h0, 16'h0, 16'h0);
      chk("R5 ctrl", reg_rdata, 32'h3000_0000);

      // R2 and R3 freeze bits with aliases
      step(1'b1, 3'd3, 2'd0, 32'h0000_000F, 16'h0, 16'h0, 16'h0);
      chk("R2 freeze write", {16'h0, chan_freeze}, 32'h0000_000F);
      step(1'b1, 3'd3, 2'd1, 32'h0000_00F0, 16'h0, 16'h0, 16'h0);
      chk("R3 set alias", reg_rdata, 32'h0000_00FF);
      step(1'b1, 3'd3, 2'd2, 32'h0000_0005, 16'h0, 16'h0, 16'h0);
      chk("R3 clear alias", reg_rdata, 32'h0000_00FA);

      // R4 reset pulse on channel 2, bit 18
      step(1'b1, 3'd3, 2'd1, 32'h0004_0000, 16'h0, 16'h0, 16'h0);
      chk("R4 pulse high", {16'h0, chan_reset}, 32'h0000_0004);
      idle(3'd3);
      chk("R4 self clear", reg_rdata, 32'h0000_00FA);

      // R9 clear in the same cycle as a completion event
      step(1'b0, 3'd1, 2'd0, 32'h0, 16'h0001, 16'h0, 16'h0);
      step(1'b1, 3'd1, 2'd2, 32'h0000_0001, 16'h0001, 16'h0, 16'h0);
      chk("R9 event beats clear", reg_rdata & 32'h1, 32'h1);

      // R8 termination error together with completion is not qualified
      step(1'b1, 3'd1, 2'd0, 32'h0, 16'h0, 16'h0, 16'h0);
      step(1'b1, 3'd2, 2'd0, 32'h0, 16'h0, 16'h0, 16'h0);
      step(1'b0, 3'd2, 2'd0, 32'h0, 16'h0004, 16'h0004, 16'h0000);
      chk("R8 term with completion", {31'h0, irq}, 32'h0);
      step(1'b0, 3'd2, 2'd0, 32'h0, 16'h0, 16'h0008, 16'h0000);
      chk("R8 term alone", {31'h0, irq}, 32'h1);
      step(1'b1, 3'd2, 2'd0, 32'h0, 16'h0, 16'h0, 16'h0);
      chk("R8 cleared", {31'h0, irq}, 32'h0);
      step(1'b1, 3'd1, 2'd1, 32'h0004_0000, 16'h0, 16'h0, 16'h0);
      chk("R8 enabled completion", {31'h0, irq}, 32'h1);

      // R7 bus error type
      step(1'b0, 3'd2, 2'd0, 32'h0, 16'h0, 16'h0010, 16'h0010);
      chk("R7 bus type", reg_rdata, 32'h0010_0010);

      // R10 version ignores writes, R11 unmapped
      step(1'b1, 3'd4, 2'd0, 32'hFFFF_FFFF, 16'h0, 16'h0, 16'h0);
      chk("R10 version", reg_rdata, 32'h0300_0000);
      step(1'b1, 3'd6, 2'd1, 32'hFFFF_FFFF, 16'h0, 16'h0, 16'h0);
      chk("R11 unmapped", reg_rdata, 32'h0);

      // random mix of writes, aliases and colliding events
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] ed, ee;
         ed = 16'($urandom & $urandom & $urandom);
         ee = 16'($urandom & $urandom & $urandom & $urandom);
         step(1'($urandom), 3'($urandom % 6), 2'($urandom), $urandom,
              ed, ee, 16'($urandom));
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule